// File: doc/BRIEF.md
# Host Pixel Word Unpacker

During a host-to-screen blit the host pushes pixel data through a single data port as 32-bit words. This block turns those words into a byte stream for the blit engine's destination writer. Bytes leave a word in ascending lane order, so bits 7:0 go first. The block counts bytes against the programmed row length and rows against the programmed row count. Every row arrives padded to a whole number of words, and the block discards the pad lanes of the last word of each row. Each byte carries a row-end flag and a frame-end flag. One cycle after the last byte of the frame is consumed, the block pulses a done flag.

The block holds at most one word. While that word is being drained, the word-ready output stays low, which stalls the host. A start pulse latches the new row length and row count, clears every counter and throws away any word it holds. This applies even in the middle of a frame.

The controller has four states:
- IDLE is entered from reset.
- FETCH waits for a word.
- DRAIN presents the bytes of the held word.
- DONE is entered after the frame.

The transitions are:
- START: any state goes to FETCH on a start pulse.
- LOAD: FETCH goes to DRAIN when a word is written.
- NEXT_WORD: DRAIN goes back to FETCH after lane 3, or after the last byte of a row that is not the last row.
- FINISH: DRAIN goes to DONE after the last byte of the last row.

Top module: `hpx_unpack`

## Requirements
- R1: After reset no byte is offered (`out_valid`=0), `frame_done` is 0 and `wr_ready` is 1.
- R2: Bytes of a word are emitted little-endian: bits 7:0 first, then 15:8, 23:16, 31:24.
- R3: A frame carries `x_last`+1 bytes per row and `y_last`+1 rows, with both values latched at start.
- R4: Each row uses ceil((`x_last`+1)/4) words. Pad lanes after the last byte of a row are never emitted, and the next row begins with lane 0 of a new word.
- R5: `out_row_end` is 1 exactly on the last byte of each row. `out_frame_end` is 1 only on the last byte of the last row.
- R6: While `out_valid`=1 and `out_ready`=0, the offered byte and its flags stay stable. `wr_ready` is 0 whenever a word is held.
- R7: `frame_done` is a one-cycle pulse in the cycle after the final byte is accepted.
- R8: Words written before any start, or after a frame completes, are accepted and dropped. No byte is emitted for them.
- R9: A start pulse in mid-frame discards the held word and clears all counters. The next word written begins row 0 at lane 0 with the new dimensions.
- R10: `wr_ready` is 1 in every state except while a word is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a frame, latching dimensions and clearing counters |
| x_last | input | XW | Bytes per row minus one |
| y_last | input | YW | Rows minus one |
| wr_en | input | 1 | Host word write strobe |
| wr_data | input | WORD_W | Host word |
| wr_ready | output | 1 | Block can take a word this cycle |
| out_valid | output | 1 | Byte offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Pixel byte |
| out_row_end | output | 1 | Last byte of a row |
| out_frame_end | output | 1 | Last byte of the frame |
| frame_done | output | 1 | Pulse after the final byte |

## Verification
If the lane counter goes wrong, the very next accepted byte comes from the wrong lane and differs from the computed pixel value. If the column or row counter goes wrong, the row-end or frame-end flag moves off its byte within one row. A stuck state shows up as `wr_ready` or `out_valid` disagreeing with the handshake history in the same cycle. Frames with stalls, pad lanes, exact-fit rows and mid-frame restarts expose each of these faults at the output within a few cycles.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DRAIN,
        ST_DONE
    } hpx_state_e;
endpackage

// File: rtl/hpx_word_buf.sv
module hpx_word_buf #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (load) begin
            dout <= din;
        end
    end
endmodule

// File: rtl/hpx_lane_sel.sv
module hpx_lane_sel #(
    parameter int WORD_W = 32,
    localparam int LANES = WORD_W / hpx_pkg::BYTE_W,
    localparam int LW    = $clog2(LANES)
) (
    input  logic [WORD_W-1:0]          word,
    input  logic [LW-1:0]              lane,
    output logic [hpx_pkg::BYTE_W-1:0] byte_o
);
    logic [hpx_pkg::BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*hpx_pkg::BYTE_W +: hpx_pkg::BYTE_W];
    end

    assign byte_o = lanes[lane];
endmodule

// File: rtl/hpx_unpack.sv
module hpx_unpack #(
    parameter int XW     = 12,
    parameter int YW     = 12,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XW-1:0]     x_last,
    input  logic [YW-1:0]     y_last,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_byte,
    output logic              out_row_end,
    output logic              out_frame_end,
    output logic              frame_done
);
    import hpx_pkg::*;

    localparam int LANES = WORD_W / BYTE_W;
    localparam int LW    = $clog2(LANES);

    hpx_state_e state, state_nxt;

    logic [XW-1:0]     col, x_lim;
    logic [YW-1:0]     row, y_lim;
    logic [LW-1:0]     lane;
    logic [WORD_W-1:0] held;
    logic              last_col, last_row, last_lane, fire, load;

    assign last_col  = (col == x_lim);
    assign last_row  = (row == y_lim);
    assign last_lane = (lane == LW'(LANES - 1));
    assign fire      = (state == ST_DRAIN) && out_ready;
    assign load      = (state == ST_FETCH) && wr_en && !start;

    hpx_word_buf #(.WORD_W(WORD_W)) u_buf (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .din  (wr_data),
        .dout (held)
    );

    hpx_lane_sel #(.WORD_W(WORD_W)) u_sel (
        .word  (held),
        .lane  (lane),
        .byte_o(out_byte)
    );

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (start) begin
            state_nxt = ST_FETCH;                        // START
        end else begin
            unique case (state)
                ST_IDLE:  state_nxt = ST_IDLE;
                ST_FETCH: if (wr_en) state_nxt = ST_DRAIN; // LOAD
                ST_DRAIN: begin
                    if (out_ready) begin
                        if (last_col)
                            state_nxt = last_row ? ST_DONE : ST_FETCH; // FINISH / NEXT_WORD
                        else if (last_lane)
                            state_nxt = ST_FETCH;                      // NEXT_WORD
                    end
                end
                ST_DONE:  state_nxt = ST_DONE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Counters and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col        <= '0;
            row        <= '0;
            lane       <= '0;
            x_lim      <= '0;
            y_lim      <= '0;
            frame_done <= 1'b0;
        end else if (start) begin
            col        <= '0;
            row        <= '0;
            lane       <= '0;
            x_lim      <= x_last;
            y_lim      <= y_last;
            frame_done <= 1'b0;
        end else begin
            frame_done <= fire && last_col && last_row;
            if (load) begin
                lane <= '0;
            end
            if (fire) begin
                if (last_col) begin
                    col <= '0;
                    row <= row + 1'b1;
                end else begin
                    col  <= col + 1'b1;
                    lane <= lane + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        wr_ready      = (state != ST_DRAIN);
        out_valid     = (state == ST_DRAIN);
        out_row_end   = out_valid && last_col;
        out_frame_end = out_valid && last_col && last_row;
    end
endmodule

// File: rtl/hpx_unpack_chk.sv
module hpx_unpack_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       wr_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [7:0] out_byte,
    input logic       out_row_end,
    input logic       out_frame_end,
    input logic       frame_done
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !start |=> out_valid && $stable(out_byte) && $stable(out_row_end)); // R6

    AST_BUSY_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !wr_ready); // R6

    AST_FRAME_END_ON_ROW_END: assert property (@(posedge clk) disable iff (!rst_n)
        out_frame_end |-> out_row_end && out_valid); // R5

    AST_ROW_END_REFETCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_row_end && !out_frame_end && !start |=> !out_valid && wr_ready); // R4

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(out_valid && out_ready && out_frame_end)); // R7

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !out_valid); // R8
endmodule

bind hpx_unpack hpx_unpack_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .wr_ready     (wr_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_byte     (out_byte),
    .out_row_end  (out_row_end),
    .out_frame_end(out_frame_end),
    .frame_done   (frame_done)
);

// File: tb/hpx_unpack_bench.sv
module hpx_unpack_bench;
    localparam int XW = 12;
    localparam int YW = 12;
    localparam int WORD_W = 32;
    localparam int NV = 6;
    // {stall, x_last, y_last}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 12'd0, 12'd0},
        {1'b0, 12'd3, 12'd2},
        {1'b1, 12'd4, 12'd1},
        {1'b1, 12'd6, 12'd3},
        {1'b0, 12'd9, 12'd0},
        {1'b1, 12'd0, 12'd4}
    };

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [XW-1:0]     x_last = '0;
    logic [YW-1:0]     y_last = '0;
    logic              wr_en = 1'b0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              wr_ready, out_valid, out_row_end, out_frame_end, frame_done;
    logic              out_ready = 1'b0;
    logic [7:0]        out_byte;

    int checks = 0;
    int fails = 0;

    hpx_unpack #(.XW(XW), .YW(YW), .WORD_W(WORD_W)) u_hpx_unpack (
        .clk(clk), .rst_n(rst_n), .start(start), .x_last(x_last), .y_last(y_last),
        .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .out_valid(out_valid),
        .out_ready(out_ready), .out_byte(out_byte), .out_row_end(out_row_end),
        .out_frame_end(out_frame_end), .frame_done(frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pix(input int id, input int r, input int c);
        return 8'(id * 37 + r * 11 + c * 3 + 1);
    endfunction

    task automatic do_start(input int x, input int y);
        @(negedge clk);
        x_last = XW'(x);
        y_last = YW'(y);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push_word(input logic [WORD_W-1:0] d);
        wr_data = d;
        wr_en = 1'b1;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic expect_quiet(input string req);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!out_valid, req, out_valid, 0);
        end
    endtask

    task automatic run_frame(input int id, input int x, input int y, input bit stall);
        do_start(x, y);
        fork
            begin : feeder
                int wpr = (x + 4) / 4;
                for (int r = 0; r <= y; r++) begin
                    for (int w = 0; w < wpr; w++) begin
                        logic [WORD_W-1:0] d;
                        for (int b = 0; b < 4; b++)
                            d[b*8 +: 8] = (w * 4 + b <= x) ? pix(id, r, w * 4 + b) : 8'hA5;
                        wr_data = d;
                        wr_en = 1'b1;
                        while (!wr_ready) @(negedge clk);
                        @(negedge clk);
                    end
                end
                wr_en = 1'b0;
            end
            begin : consumer
                int n = 0;
                int total = (x + 1) * (y + 1);
                int cyc = 0;
                while (n < total) begin
                    out_ready = !(stall && (cyc % 3 == 1));
                    cyc++;
                    if (out_valid && out_ready) begin
                        int r = n / (x + 1);
                        int c = n % (x + 1);
                        chk(out_byte == pix(id, r, c), "R2 R4 byte", out_byte, pix(id, r, c));
                        chk(out_row_end == (c == x), "R5 row_end", out_row_end, (c == x));
                        chk(out_frame_end == (n == total - 1), "R5 frame_end", out_frame_end, (n == total - 1));
                        n++;
                    end
                    @(negedge clk);
                end
                out_ready = 1'b1;
                chk(frame_done == 1'b1, "R7 done pulse", frame_done, 1);
                chk(out_valid == 1'b0, "R3 no extra byte", out_valid, 0);
            end
        join
        @(negedge clk);
        chk(frame_done == 1'b0, "R7 pulse width", frame_done, 0);
        chk(wr_ready == 1'b1, "R10 ready in done", wr_ready, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk(!out_valid, "R1 valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R1 valid", out_valid, 0);
        chk(!frame_done, "R1 done", frame_done, 0);
        chk(wr_ready, "R1 wr_ready", wr_ready, 1);

        // R8: word before any start is dropped
        out_ready = 1'b1;
        push_word(32'hDEADBEEF);
        expect_quiet("R8 before start");

        // Table-driven frames (R2 R3 R4 R5 R7)
        for (int i = 0; i < NV; i++) begin
            run_frame(i, int'(VEC[i][23:12]), int'(VEC[i][11:0]), VEC[i][24]);
            if (i == 0) begin
                push_word(32'h01020304);
                expect_quiet("R8 after frame");
            end
        end

        // R6: backpressure holds byte and blocks writes
        do_start(3, 0);
        out_ready = 1'b0;
        push_word(32'h8C7B6A59);
        chk(out_valid && out_byte == 8'h59, "R6 first offer", out_byte, 8'h59);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_byte == 8'h59 && out_valid, "R6 stable byte", out_byte, 8'h59);
            chk(!wr_ready, "R6 wr blocked", wr_ready, 0);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_byte == 8'h6A, "R2 lane1", out_byte, 8'h6A);
        @(negedge clk);
        @(negedge clk);
        chk(out_byte == 8'h8C && out_frame_end, "R2 lane3 frame_end", out_byte, 8'h8C);
        @(negedge clk);
        chk(frame_done, "R7 done after stall", frame_done, 1);

        // R9: restart mid-frame
        do_start(7, 1);
        push_word(32'h13121110);
        @(negedge clk);
        @(negedge clk);
        out_ready = 1'b0;
        x_last = XW'(1);
        y_last = YW'(0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!out_valid, "R9 held word dropped", out_valid, 0);
        chk(wr_ready, "R10 ready after restart", wr_ready, 1);
        push_word(32'h44332211);
        out_ready = 1'b1;
        chk(out_byte == 8'h11 && !out_row_end, "R9 restart lane0", out_byte, 8'h11);
        @(negedge clk);
        chk(out_byte == 8'h22 && out_row_end && out_frame_end, "R9 new dims end", out_byte, 8'h22);
        @(negedge clk);
        chk(frame_done && !out_valid, "R9 done with new dims", frame_done, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule